// File: doc/BRIEF.md
# Residual-Current Monitor Status Indicator Driver

This block turns the status flags of a residual-current protection sequencer into the drive pattern of a single indicator output. Whenever the indicator is lit, the output is not held high: it toggles as a fixed-frequency square wave with 50% duty, which saves drive power without any visible difference. A prescaler derives this tone from the system clock. Blink timing is counted in mains line cycles, using a one-clock pulse that the sequencer raises once per line cycle.

The indication depends on two things. The first is the level of the switch-open input: held low, or left floating. The second is what happened: a passed first self-test, a self-test failure (end of life) or a ground fault. With the switch held low the indicator is steadily lit, and only an end-of-life failure makes it blink. With the switch floating the indicator stays dark, and a ground fault leaves it dark. A passed first self-test gives one single blink, and an end-of-life failure gives endless blinking. A reset that is followed by a passed self-test ends the blinking and returns the indicator to the normal state for the current mode.

The controller has seven states. `ST_DARK` is unlit and `ST_STEADY` is lit. `ST_SGL_WAIT` and `ST_SGL_ON` wait for the next line tick and then show one lit phase. `ST_BLK_WAIT`, `ST_BLK_ON` and `ST_BLK_OFF` wait for the next line tick and then alternate lit and dark phases. The transitions are named as follows:
- *follow-mode* moves between `ST_DARK` and `ST_STEADY` with the switch level.
- *single-arm* goes from `ST_DARK` to `ST_SGL_WAIT` on a first-pass pulse while floating.
- *single-go* goes from `ST_SGL_WAIT` to `ST_SGL_ON` on a tick.
- *single-end* goes from `ST_SGL_ON` to `ST_DARK` after the phase.
- *single-abort* goes from either single state to `ST_STEADY` when the switch goes low.
- *eol-arm* goes from any non-blinking state to `ST_BLK_WAIT`.
- *blink-go* goes from `ST_BLK_WAIT` to `ST_BLK_ON` on a tick.
- *blink-dim* and *blink-lit* alternate between `ST_BLK_ON` and `ST_BLK_OFF` after each phase.
- *clear* goes from any blinking state to the base state of the current mode on a reset-pass pulse.

Top module: `alarm_ind`

## Requirements
- R1: A lit indicator toggles every HALF = CLK_HZ/(2*TONE_HZ) clocks, so its period is 2*HALF clocks and its duty is exactly 50%. With the bench parameters HALF is 10.
- R2: After an end-of-life event the indicator blinks without end. Each lit phase lasts BLINK_CYC line ticks and each dark phase lasts BLINK_CYC line ticks, in either switch mode.
- R3: With `sw_low`=1 and no end-of-life state, the indicator is steadily lit, and line ticks do not change that.
- R4: With `sw_low`=0 and no end-of-life state, the indicator is dark. `gnd_fault` has no effect on the indication in either mode.
- R5: With `sw_low`=0 in the dark state, a `first_pass` pulse gives exactly one lit phase of BLINK_CYC ticks. That phase starts at the next line tick, and the indicator is dark again afterwards with no repeat. If `sw_low` goes to 1 during this sequence, the indicator goes to steady lit.
- R6: A `rst_pass` pulse while blinking, or while waiting to blink, puts the indicator in the base state of the current mode from the next clock: lit if `sw_low`=1, dark if `sw_low`=0. Outside blinking, `rst_pass` has no effect.
- R7: After an end-of-life event the indicator is dark until the next line tick, and the first lit phase starts at that tick.
- R8: When pulses arrive in the same clock, `eol_evt` takes priority over `rst_pass`, which takes priority over `first_pass`. An `eol_evt` together with `rst_pass` while blinking restarts the wait of R7. A lone `eol_evt` while blinking does not disturb the blink.
- R9: `first_pass` is ignored while `sw_low`=1 and while blinking.
- R10: The indicator is dark while `rst_n` is low. After release the controller is dark, and it moves to steady lit one clock later if `sw_low`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_tick | input | 1 | One-clock pulse per mains line cycle |
| first_pass | input | 1 | Pulse: first self-test after power-up passed |
| eol_evt | input | 1 | Pulse: self-test failure, end-of-life state entered |
| gnd_fault | input | 1 | Ground-fault flag from the sequencer |
| sw_low | input | 1 | Switch-open input level: 1 = held low, 0 = floating |
| rst_pass | input | 1 | Pulse: reset whose follow-up self-test passed |
| ind_out | output | 1 | Indicator drive: square wave when lit, 0 when dark |

## Verification
The hardest situation to bring about is a pair of coincident pulses that land while the blink sequence is partway through a phase. One such case is an end-of-life event in the same clock as a reset-pass while lit. Another is a first-pass pulse during a dark blink phase. The bench gets there by first walking the controller through whole lit and dark phases, one line tick at a time. It then drives the pulse pair on one negative clock edge. Lit versus dark is judged from the number of high samples over two full tone periods, and this count does not depend on where the free-running tone is in its cycle.

// File: rtl/ind_pkg.sv
package ind_pkg;

    typedef enum logic [2:0] {
        ST_DARK     = 3'd0,
        ST_STEADY   = 3'd1,
        ST_SGL_WAIT = 3'd2,
        ST_SGL_ON   = 3'd3,
        ST_BLK_WAIT = 3'd4,
        ST_BLK_ON   = 3'd5,
        ST_BLK_OFF  = 3'd6
    } ind_state_t;

    function automatic logic state_lit(input ind_state_t s);
        return (s == ST_STEADY) || (s == ST_SGL_ON) || (s == ST_BLK_ON);
    endfunction

    function automatic logic state_blinking(input ind_state_t s);
        return (s == ST_BLK_WAIT) || (s == ST_BLK_ON) || (s == ST_BLK_OFF);
    endfunction

endpackage

// File: rtl/tone_gen.sv
module tone_gen #(
    parameter int CLK_HZ  = 1_200_000,
    parameter int TONE_HZ = 3000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tone
);
    localparam int HALF = (CLK_HZ / (2 * TONE_HZ) < 1) ? 1 : CLK_HZ / (2 * TONE_HZ);
    localparam int CW   = $clog2(HALF + 1);

    logic [CW-1:0] cnt_q;
    logic          tone_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tone_q <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            tone_q <= ~tone_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign tone = tone_q;

    p_half_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != CW'(HALF - 1)) |=> $stable(tone_q));

    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(HALF));

endmodule

// File: rtl/phase_ctr.sv
module phase_ctr #(
    parameter int BLINK_CYC = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    output logic done
);
    localparam int PW = $clog2(BLINK_CYC + 1);

    logic [PW-1:0] cnt_q;

    assign done = tick && (cnt_q == PW'(BLINK_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= done ? '0 : cnt_q + 1'b1;
    end

    p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < PW'(BLINK_CYC));

    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/ind_fsm.sv
module ind_fsm
    import ind_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_tick,
    input  logic first_pass,
    input  logic eol_evt,
    input  logic gnd_fault,
    input  logic sw_low,
    input  logic rst_pass,
    input  logic phase_done,
    output logic phase_clr,
    output logic ind_on
);
    ind_state_t state_q, state_d;
    ind_state_t base_st;
    logic       blinking;

    assign blinking = state_blinking(state_q);
    assign base_st  = sw_low ? ST_STEADY : ST_DARK;

    // next state
    always_comb begin
        state_d = state_q;
        if (eol_evt && (!blinking || rst_pass)) begin
            state_d = ST_BLK_WAIT;
        end else if (rst_pass && blinking) begin
            state_d = base_st;
        end else begin
            unique case (state_q)
                ST_DARK: begin
                    if (sw_low)          state_d = ST_STEADY;
                    else if (first_pass) state_d = ST_SGL_WAIT;
                end
                ST_STEADY: begin
                    if (!sw_low)         state_d = ST_DARK;
                end
                ST_SGL_WAIT: begin
                    if (sw_low)          state_d = ST_STEADY;
                    else if (line_tick)  state_d = ST_SGL_ON;
                end
                ST_SGL_ON: begin
                    if (sw_low)          state_d = ST_STEADY;
                    else if (phase_done) state_d = ST_DARK;
                end
                ST_BLK_WAIT: begin
                    if (line_tick)       state_d = ST_BLK_ON;
                end
                ST_BLK_ON: begin
                    if (phase_done)      state_d = ST_BLK_OFF;
                end
                ST_BLK_OFF: begin
                    if (phase_done)      state_d = ST_BLK_ON;
                end
                default:                 state_d = ST_DARK;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DARK;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        ind_on    = state_lit(state_q);
        phase_clr = (state_d != state_q);
    end

    p_wait_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLK_WAIT && !line_tick && !rst_pass)
        |=> (state_q == ST_BLK_WAIT));

    p_eol_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eol_evt && (rst_pass || !blinking)) |=> (state_q == ST_BLK_WAIT));

    p_reset_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_pass && !eol_evt && blinking)
        |=> (state_q == ST_DARK || state_q == ST_STEADY));

    p_first_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (first_pass && blinking && !rst_pass && !eol_evt)
        |=> state_blinking(state_q));

    p_fault_no_effect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnd_fault && state_q == ST_DARK && !sw_low && !eol_evt && !first_pass)
        |=> (state_q == ST_DARK));

endmodule

// File: rtl/alarm_ind.sv
module alarm_ind #(
    parameter int CLK_HZ    = 1_200_000,
    parameter int TONE_HZ   = 3000,
    parameter int BLINK_CYC = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_tick,
    input  logic first_pass,
    input  logic eol_evt,
    input  logic gnd_fault,
    input  logic sw_low,
    input  logic rst_pass,
    output logic ind_out
);
    logic tone;
    logic ind_on;
    logic phase_done;
    logic phase_clr;

    tone_gen #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ)) u_tone (
        .clk   (clk),
        .rst_n (rst_n),
        .tone  (tone)
    );

    phase_ctr #(.BLINK_CYC(BLINK_CYC)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (line_tick),
        .clr   (phase_clr),
        .done  (phase_done)
    );

    ind_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_tick  (line_tick),
        .first_pass (first_pass),
        .eol_evt    (eol_evt),
        .gnd_fault  (gnd_fault),
        .sw_low     (sw_low),
        .rst_pass   (rst_pass),
        .phase_done (phase_done),
        .phase_clr  (phase_clr),
        .ind_on     (ind_on)
    );

    assign ind_out = ind_on & tone;

    p_dark_in_reset_r10: assert property (@(posedge clk)
        !rst_n |-> !ind_out);

endmodule

// File: tb/alarm_ind_test.sv
module alarm_ind_test;
    localparam int CLK_PERIOD = 10;
    localparam int CYC        = 3;
    localparam int WIN        = 40;
    localparam int LIT        = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_tick = 1'b0, first_pass = 1'b0, eol_evt = 1'b0;
    logic gnd_fault = 1'b0, sw_low = 1'b0, rst_pass = 1'b0;
    logic ind_out;
    int   checks = 0;
    int   failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_ind #(.CLK_HZ(60000), .TONE_HZ(3000), .BLINK_CYC(CYC)) uut (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .first_pass(first_pass),
        .eol_evt(eol_evt), .gnd_fault(gnd_fault), .sw_low(sw_low),
        .rst_pass(rst_pass), .ind_out(ind_out)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic measure(input int n, output int highs, output int trans);
        logic prev;
        highs = 0; trans = 0; prev = ind_out;
        for (int i = 0; i < n; i++) begin
            if (ind_out) highs++;
            if (i > 0 && ind_out != prev) trans++;
            prev = ind_out;
            @(negedge clk);
        end
    endtask

    task automatic win(input string req, input int exp);
        int h, t;
        measure(WIN, h, t);
        chk(req, h, exp);
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0; sw_low = mode;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic tick_win(input string req, input int exp);
        line_tick = 1'b1; @(negedge clk); line_tick = 1'b0;
        win(req, exp);
    endtask

    task automatic t_reset();
        int h, t;
        @(negedge clk); rst_n = 1'b0; sw_low = 1'b1;
        measure(WIN, h, t);
        chk("R10 dark in reset", h, 0);
        do_reset(1'b0);
        win("R10 dark after release floating", 0);
        do_reset(1'b1);
        win("R10 lit after release held low", LIT);
    endtask

    task automatic t_tone();
        int h, t;
        do_reset(1'b1);
        for (int k = 0; k < 3; k++) begin
            measure(20, h, t);
            chk("R1 half duty", h, 10);
            repeat (k + 3) @(negedge clk);
            measure(21, h, t);
            chk("R1 toggle period", t, 2);
        end
    endtask

    task automatic t_steady();
        do_reset(1'b1);
        gnd_fault = 1'b1; @(negedge clk); gnd_fault = 1'b0;
        win("R4 fault held low stays lit", LIT);
        tick_win("R3 steady across tick", LIT);
        tick_win("R3 steady across tick", LIT);
        sw_low = 1'b0; @(negedge clk);
        win("R4 floating dark", 0);
        gnd_fault = 1'b1; @(negedge clk); gnd_fault = 1'b0;
        win("R4 fault floating dark", 0);
        tick_win("R4 fault floating dark after tick", 0);
    endtask

    task automatic t_single();
        do_reset(1'b0);
        first_pass = 1'b1; @(negedge clk); first_pass = 1'b0;
        win("R5 dark before tick", 0);
        for (int k = 0; k < CYC; k++) tick_win("R5 single lit phase", LIT);
        for (int k = 0; k < 2 * CYC; k++) tick_win("R5 no repeat", 0);
        first_pass = 1'b1; @(negedge clk); first_pass = 1'b0;
        tick_win("R5 second single lit", LIT);
        sw_low = 1'b1; @(negedge clk);
        for (int k = 0; k < CYC + 1; k++) tick_win("R5 abort to steady", LIT);
        first_pass = 1'b1; @(negedge clk); first_pass = 1'b0;
        sw_low = 1'b0; @(negedge clk);
        win("R9 first_pass ignored held low", 0);
        tick_win("R9 first_pass ignored held low", 0);
    endtask

    task automatic t_blink();
        do_reset(1'b1);
        eol_evt = 1'b1; @(negedge clk); eol_evt = 1'b0;
        win("R7 dark until tick", 0);
        win("R7 dark until tick", 0);
        for (int r = 0; r < 2; r++) begin
            for (int k = 0; k < CYC; k++) tick_win("R2 lit phase", LIT);
            for (int k = 0; k < CYC; k++) tick_win("R2 dark phase", 0);
        end
        first_pass = 1'b1; eol_evt = 1'b1; @(negedge clk);
        first_pass = 1'b0; eol_evt = 1'b0;
        for (int k = 0; k < CYC; k++) tick_win("R9 R8 blink undisturbed lit", LIT);
        tick_win("R9 blink undisturbed dark", 0);
        rst_pass = 1'b1; @(negedge clk); rst_pass = 1'b0;
        win("R6 clear to steady", LIT);
        tick_win("R6 stays steady", LIT);
    endtask

    task automatic t_clear_float();
        do_reset(1'b0);
        eol_evt = 1'b1; @(negedge clk); eol_evt = 1'b0;
        tick_win("R2 floating blink lit", LIT);
        rst_pass = 1'b1; @(negedge clk); rst_pass = 1'b0;
        win("R6 clear to dark", 0);
        for (int k = 0; k < CYC + 1; k++) tick_win("R6 stays dark", 0);
        rst_pass = 1'b1; @(negedge clk); rst_pass = 1'b0;
        sw_low = 1'b1; @(negedge clk);
        win("R6 rst_pass idle no effect", LIT);
    endtask

    task automatic t_priority();
        do_reset(1'b1);
        eol_evt = 1'b1; @(negedge clk); eol_evt = 1'b0;
        tick_win("R8 setup lit", LIT);
        eol_evt = 1'b1; rst_pass = 1'b1; @(negedge clk);
        eol_evt = 1'b0; rst_pass = 1'b0;
        win("R8 eol beats reset", 0);
        tick_win("R8 restart lit", LIT);
        do_reset(1'b0);
        eol_evt = 1'b1; first_pass = 1'b1; @(negedge clk);
        eol_evt = 1'b0; first_pass = 1'b0;
        for (int k = 0; k < CYC; k++) tick_win("R8 eol beats first_pass lit", LIT);
        for (int k = 0; k < CYC; k++) tick_win("R8 eol beats first_pass dark", 0);
        tick_win("R8 blink resumes", LIT);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_tone();
        t_steady();
        t_single();
        t_blink();
        t_clear_float();
        t_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule